// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block produces the fetch address for a single-issue 32-bit core whose control-transfer instructions have one architectural delay slot. Every cycle the front end presents the resolution of the instruction being issued at the current address: whether it is a control transfer, whether it is taken, its destination, and whether it is of the kind that annuls its slot when it falls through. A stall input freezes the sequencer.

A taken transfer does not redirect at once. The instruction at the following word, the delay slot, is issued first, and the destination is loaded into the PC in the cycle after that slot issues. A transfer of the annulling kind that falls through still issues its slot, tagged as annulled so that later stages drop its writes, and fetch resumes two words past the transfer. A control transfer found sitting in a delay slot is an unpredictable program; the sequencer raises a fault flag for that cycle, ignores the second redirect and honours the first.

The condition input is taken as given. No interlock is placed between whatever produced a condition and the transfer that tests it.

Top module: `ds_pc_seq`

## Requirements
- R1: While reset is asserted the fetch address equals the BOOT_PC parameter (default 0x400) and the annul output is 0; after reset no slot is pending, so the first instruction is neither annulled nor faulted and its successor is at BOOT_PC + 4.
- R2: When an issued instruction is not a control transfer and no slot is pending, the next issued address is the current address + 4.
- R3: A taken transfer at address A causes the next issued address to be A + 4 (the slot) and the one after it to be the transfer's destination.
- R4: An ordinary (non-annulling) transfer that is not taken issues its slot at A + 4 with annul = 0, and fetch continues at A + 8.
- R5: An annulling transfer (likely input = 1) that is not taken issues its slot at A + 4 with valid = 1 and annul = 1, and fetch continues at A + 8.
- R6: An annulling transfer that is taken issues its slot with annul = 0 and then continues at its destination.
- R7: While stall is 1, valid is 0, annul is 0 and the fetch address holds; a pending redirect and a pending annul survive the stall and act when the slot is finally issued.
- R8: A control transfer issued in a delay slot raises the fault output for that cycle; its own taken, likely and destination inputs are ignored and the first transfer's outcome (destination or A + 8) decides the next address.
- R9: When the transfer input is 0, the taken, likely and destination inputs have no effect on the next address or on annulling.
- R10: The fault output is 1 only for an issued instruction that is in a delay slot and flagged as a transfer; it is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 holds the sequencer; no instruction issues |
| xfer_i | input | 1 | 1 if the instruction issued now is a control transfer |
| taken_i | input | 1 | 1 if that transfer is taken |
| likely_i | input | 1 | 1 if that transfer annuls its slot when not taken |
| target_i | input | AW | Destination address of that transfer |
| fetch_pc_o | output | AW | Address of the instruction issued this cycle |
| issue_vld_o | output | 1 | 1 when an instruction issues this cycle |
| issue_annul_o | output | 1 | 1 when the issued instruction is an annulled slot |
| slot_fault_o | output | 1 | 1 when a transfer is issued inside a delay slot |

## Verification
The address stream is driven through straight-line code, taken and fall-through ordinary transfers, and taken and fall-through annulling transfers, which separates a redirect applied one instruction early or late from a correct one and an annul placed on the wrong kind of transfer. Stalls are inserted on a slot with a pending redirect and on a slot with a pending annul, showing whether that pending state is lost or applied while frozen. A transfer placed in a slot, both behind a taken and behind a fall-through transfer, shows which redirect wins, and asserted condition inputs on plain instructions show that they are ignored. Reset is applied with a redirect and with an annul pending to show that neither leaks past it.

// File: rtl/ds_pc_seq.sv
module ds_pc_seq #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BOOT_PC = 32'h0000_0400,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          xfer_i,
  input  logic          taken_i,
  input  logic          likely_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic          issue_vld_o,
  output logic          issue_annul_o,
  output logic          slot_fault_o
);
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic [AW-1:0] pc_q, tgt_q;
  logic          slot_q, redir_q, annul_q;

  wire adv = ~stall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= BOOT_PC;
      tgt_q   <= '0;
      slot_q  <= 1'b0;
      redir_q <= 1'b0;
      annul_q <= 1'b0;
    end else if (adv) begin
      if (slot_q) begin
        pc_q    <= redir_q ? tgt_q : pc_q + INC;
        slot_q  <= 1'b0;
        redir_q <= 1'b0;
        annul_q <= 1'b0;
      end else begin
        pc_q    <= pc_q + INC;
        slot_q  <= xfer_i;
        redir_q <= xfer_i & taken_i;
        annul_q <= xfer_i & likely_i & ~taken_i;
        if (xfer_i) tgt_q <= target_i;
      end
    end
  end

  assign fetch_pc_o    = pc_q;
  assign issue_vld_o   = adv;
  assign issue_annul_o = adv & slot_q & annul_q;
  assign slot_fault_o  = adv & slot_q & xfer_i;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> fetch_pc_o == $past(fetch_pc_o));

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !xfer_i && !issue_annul_o && !$isunknown(fetch_pc_o) && !slot_q)
      |=> fetch_pc_o == $past(fetch_pc_o) + INC);

  p_slot_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && xfer_i && !slot_q) |=> fetch_pc_o == $past(fetch_pc_o) + INC);

  p_annul_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && xfer_i && likely_i && !taken_i && !slot_q)
      |=> (stall_i || issue_annul_o));

  p_fault_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault_o |=> !slot_fault_o);

  p_annul_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_annul_o |-> issue_vld_o);
endmodule

// File: tb/ds_pc_seq_test.sv
module ds_pc_seq_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] BOOT = 32'h0000_0400;

  typedef struct packed {
    logic          st;
    logic          br;
    logic          tk;
    logic          lk;
    logic [AW-1:0] tgt;
    logic [AW-1:0] pc;
    logic          an;
    logic          flt;
  } vec_t;

  function automatic vec_t mk(logic st, logic br, logic tk, logic lk,
                              logic [AW-1:0] tgt, logic [AW-1:0] pc,
                              logic an, logic flt);
    mk = '{st, br, tk, lk, tgt, pc, an, flt};
  endfunction

  localparam int NV = 27;
  localparam vec_t V [NV] = '{
    mk(0,0,0,0,32'h0,   32'h400,0,0), // R1 first instr, R2
    mk(0,0,0,0,32'h0,   32'h404,0,0), // R2
    mk(0,1,1,0,32'h800, 32'h408,0,0), // R3 taken
    mk(0,0,0,0,32'h0,   32'h40C,0,0), // R3 slot
    mk(0,0,0,0,32'h0,   32'h800,0,0), // R3 destination
    mk(0,1,0,0,32'h900, 32'h804,0,0), // R4 not taken
    mk(0,0,0,0,32'h0,   32'h808,0,0), // R4 slot kept
    mk(0,1,0,1,32'hA00, 32'h80C,0,0), // R5 annulling, not taken
    mk(0,0,0,0,32'h0,   32'h810,1,0), // R5 slot annulled
    mk(0,1,1,1,32'hB00, 32'h814,0,0), // R6 annulling, taken
    mk(0,0,0,0,32'h0,   32'h818,0,0), // R6 slot kept
    mk(0,1,1,0,32'hC00, 32'hB00,0,0), // R6 destination, R8 first transfer
    mk(1,0,0,0,32'h0,   32'hB04,0,0), // R7 stall on slot
    mk(1,0,0,0,32'h0,   32'hB04,0,0), // R7 stall on slot
    mk(0,1,1,0,32'hD00, 32'hB04,0,1), // R8 transfer in slot
    mk(0,0,0,0,32'h0,   32'hC00,0,0), // R8 first destination wins
    mk(0,1,0,1,32'hE00, 32'hC04,0,0), // R7 annul pending
    mk(1,0,0,0,32'h0,   32'hC08,0,0), // R7 stalled, annul 0
    mk(0,0,0,0,32'h0,   32'hC08,1,0), // R7 annul survives stall
    mk(0,0,1,1,32'hF00, 32'hC0C,0,0), // R9 inputs ignored
    mk(0,0,0,0,32'h0,   32'hC10,0,0), // R9
    mk(0,1,0,0,32'h700, 32'hC14,0,0), // R8 fall-through first
    mk(0,1,1,0,32'h700, 32'hC18,0,1), // R8 slot transfer ignored
    mk(0,0,0,0,32'h0,   32'hC1C,0,0), // R8 A+8, R10
    mk(1,0,0,0,32'h0,   32'hC20,0,0), // R7 stall outside slot
    mk(0,0,0,0,32'h0,   32'hC20,0,0), // R7
    mk(0,0,0,0,32'h0,   32'hC24,0,0)  // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall_i = 0, xfer_i = 0, taken_i = 0, likely_i = 0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] fetch_pc_o;
  logic issue_vld_o, issue_annul_o, slot_fault_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ds_pc_seq #(.AW(AW), .BOOT_PC(BOOT), .STEP(4)) uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .xfer_i(xfer_i),
    .taken_i(taken_i), .likely_i(likely_i), .target_i(target_i),
    .fetch_pc_o(fetch_pc_o), .issue_vld_o(issue_vld_o),
    .issue_annul_o(issue_annul_o), .slot_fault_o(slot_fault_o));

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic st, logic br, logic tk, logic lk, logic [AW-1:0] tg);
    stall_i = st; xfer_i = br; taken_i = tk; likely_i = lk; target_i = tg;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(0,0,0,0,'0);
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset pc", fetch_pc_o, BOOT);
    chk("R1 reset annul", {31'b0, issue_annul_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(V[i].st, V[i].br, V[i].tk, V[i].lk, V[i].tgt);
      #1;
      chk($sformatf("vec%0d pc (R2-R9)", i), fetch_pc_o, V[i].pc);
      chk($sformatf("vec%0d valid R7", i), {31'b0, issue_vld_o}, {31'b0, ~V[i].st});
      chk($sformatf("vec%0d annul R5", i), {31'b0, issue_annul_o}, {31'b0, V[i].an});
      chk($sformatf("vec%0d fault R10", i), {31'b0, slot_fault_o}, {31'b0, V[i].flt});
      @(negedge clk);
    end

    // R1: reset with a taken redirect pending
    drive(0,1,1,0,32'h900);
    @(negedge clk);
    drive(0,0,0,0,'0);
    rst_n = 1'b0;
    #1;
    chk("R1 reset over pending redirect pc", fetch_pc_o, BOOT);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first pc after reset", fetch_pc_o, BOOT);
    @(negedge clk);
    #1;
    chk("R1 no stale redirect", fetch_pc_o, BOOT + 4);
    chk("R1 no stale annul", {31'b0, issue_annul_o}, 0);

    // R1: reset with an annul pending
    drive(0,1,0,1,32'h900);
    @(negedge clk);
    drive(0,0,0,0,'0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 annul cleared by reset", {31'b0, issue_annul_o}, 0);
    chk("R1 fault clear after reset", {31'b0, slot_fault_o}, 0);

    // R9: destination ignored when not a transfer, twice in a row
    drive(0,0,1,0,32'h1234);
    @(negedge clk);
    #1;
    chk("R9 plain with taken set", fetch_pc_o, BOOT + 4);
    @(negedge clk);
    #1;
    chk("R9 still sequential", fetch_pc_o, BOOT + 8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule